// File: doc/BRIEF.md
# Configuration Access Port Translator

This host-bridge block turns processor I/O accesses into configuration bus cycles. The processor writes a 32-bit address word to an address port at I/O `0x0CF8`. That word selects an enable flag, a bus, a device, a function and a doubleword. Any later access to the data port at `0x0CFC`–`0x0CFF` then launches one configuration cycle, provided the enable flag is set. The block presents the cycle as an address-phase AD word, a command code and a one-hot device select vector, all registered.

The cycle type depends on the bus number in the address word. If it equals the `local_bus` input, the cycle is a local type 0 cycle. The device number becomes a one-hot select, which is also placed on the upper AD bits. If the bus numbers differ, the cycle is a forwarded type 1 cycle. It carries the bus, device, function and doubleword fields unchanged, so that a downstream bridge can route it. The data phase, parity and bus-range windows belong to other logic.

Top module: `cfg_port_xlate`

## Requirements
- R1: After reset the address word is zero, `cyc_valid` is 0, and `cyc_type1`, `cyc_cmd`, `cyc_ad` and `cyc_idsel` are all zero.
- R2: A write to the address port with all four byte enables set stores the word. Bits 30:24 and 1:0 are stored as zero. A full-width read of the address port returns the stored word on `io_rdata` in the same cycle.
- R3: A write to the address port with any byte enable clear leaves the stored word unchanged. A read of the address port that is not full width returns zero.
- R4: A data-port access made while bit 31 of the stored word is 0 produces no cycle. The same holds for a data-port access with all byte enables clear. In both cases `cyc_valid` stays 0 and the cycle outputs keep their values.
- R5: When the bus field (bits 23:16) equals `local_bus`, the cycle is type 0 and `cyc_type1` is 0. `cyc_ad` carries the function in bits 10:8 and the doubleword in bits 7:2. Bits 15:11 and 1:0 are zero.
- R6: In a type 0 cycle with device number n (bits 15:11) below NSLOT, `cyc_idsel` has only bit n set, and `cyc_ad` bit 16+n is the only AD bit set above bit 10.
- R7: In a type 0 cycle with a device number of NSLOT or more, `cyc_idsel` is zero and `cyc_ad[31:11]` is zero.
- R8: When the bus field differs from `local_bus`, the cycle is type 1 and `cyc_type1` is 1. `cyc_ad` is `{8'h00, bus, device, function, doubleword, 2'b01}` and `cyc_idsel` is zero.
- R9: `cyc_cmd` is 4'b1010 for a data-port read and 4'b1011 for a data-port write.
- R10: A data-port access on any byte lane (`0x0CFC`–`0x0CFF`) raises `cyc_valid` for exactly the next cycle. Between launches the cycle outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | Processor I/O access this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | IO_AW | I/O byte address |
| io_be | input | 4 | Byte enables |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data of the address port |
| local_bus | input | 8 | Number of the bus directly below the bridge |
| cyc_valid | output | 1 | One-cycle launch of a configuration cycle |
| cyc_type1 | output | 1 | 1 = forwarded type 1 cycle |
| cyc_cmd | output | 4 | Configuration command code |
| cyc_ad | output | 32 | Address-phase AD word |
| cyc_idsel | output | NSLOT | One-hot device select for type 0 |

## Verification
The bench targets three boundaries of the device decode: device 0, the last slot, and the first device number past the slots. A decoder that is off by one at any of these would light the wrong select, or a select that does not exist. It sets the bus field both equal to and different from `local_bus`. Swapping the type rule or the low AD bits would then show up as a wrong `cyc_ad` code. It also issues partial-width address writes, data accesses with the enable flag clear, and data accesses with no byte enables. A design that latched the partial word or launched a spurious cycle would show a changed readback or an unexpected `cyc_valid` pulse. Reserved bits written as ones must read back as zero.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;

    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    // Bits of the address word that hold state (enable, bus, dev, fn, dword)
    localparam logic [31:0] ADDR_KEEP_MASK = 32'h80FF_FFFC;

    localparam int EN_BIT  = 31;
    localparam int BUS_LSB = 16;
    localparam int DEV_LSB = 11;
    localparam int FN_LSB  = 8;
    localparam int DW_LSB  = 2;

    typedef struct packed {
        logic        valid;
        logic        type1;
        logic [3:0]  cmd;
        logic [31:0] ad;
    } cyc_t;

endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
    import cfg_xlate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] addr_q
);

    logic [31:0] addr_d;

    always_comb begin
        addr_d = addr_q;
        if (wr_en) begin
            addr_d = wdata & ADDR_KEEP_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

endmodule

// File: rtl/cfg_idsel_dec.sv
module cfg_idsel_dec #(
    parameter int NSLOT = 8
) (
    input  logic [4:0]       dev,
    output logic [NSLOT-1:0] sel
);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign sel[g] = (dev == 5'(g));
    end

endmodule

// File: rtl/cfg_cycle_fmt.sv
module cfg_cycle_fmt
    import cfg_xlate_pkg::*;
#(
    parameter int NSLOT = 8
) (
    input  logic [31:0]      addr_q,
    input  logic [7:0]       local_bus,
    input  logic [NSLOT-1:0] sel,
    output logic             type1,
    output logic [31:0]      ad
);

    localparam int SELW = 16;

    logic [SELW-1:0] sel_wide;

    always_comb begin
        sel_wide = SELW'(sel);
        type1    = (addr_q[BUS_LSB+7:BUS_LSB] != local_bus);
        if (type1) begin
            ad = {8'h00, addr_q[BUS_LSB+7:DW_LSB], 2'b01};
        end else begin
            ad = {sel_wide, 5'b00000, addr_q[DEV_LSB-1:DW_LSB], 2'b00};
        end
    end

endmodule

// File: rtl/cfg_port_xlate.sv
module cfg_port_xlate
    import cfg_xlate_pkg::*;
#(
    parameter int                IO_AW     = 16,
    parameter int                NSLOT     = 8,
    parameter logic [IO_AW-1:0]  ADDR_PORT = IO_AW'(16'h0CF8),
    parameter logic [IO_AW-1:0]  DATA_PORT = IO_AW'(16'h0CFC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [3:0]        io_be,
    input  logic [31:0]       io_wdata,
    output logic [31:0]       io_rdata,
    input  logic [7:0]        local_bus,
    output logic              cyc_valid,
    output logic              cyc_type1,
    output logic [3:0]        cyc_cmd,
    output logic [31:0]       cyc_ad,
    output logic [NSLOT-1:0]  cyc_idsel
);

    localparam int DW_AW = IO_AW - 2;

    if (NSLOT < 1 || NSLOT > 16) begin : g_bad_nslot
        $error("NSLOT must lie in 1..16");
    end

    logic             hit_addr;
    logic             hit_data;
    logic             full_be;
    logic             addr_wr;
    logic             launch;
    logic [31:0]      addr_q;
    logic [NSLOT-1:0] sel;
    logic             fmt_type1;
    logic [31:0]      fmt_ad;

    cyc_t             cyc_d, cyc_q;
    logic [NSLOT-1:0] idsel_d, idsel_q;

    assign hit_addr = io_valid && (io_addr[IO_AW-1:2] == ADDR_PORT[IO_AW-1:2]);
    assign hit_data = io_valid && (io_addr[IO_AW-1:2] == DATA_PORT[IO_AW-1:2]);
    assign full_be  = &io_be;
    assign addr_wr  = hit_addr && io_write && full_be;
    assign launch   = hit_data && (|io_be) && addr_q[EN_BIT];

    cfg_addr_reg u_areg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (addr_wr),
        .wdata  (io_wdata),
        .addr_q (addr_q)
    );

    cfg_idsel_dec #(.NSLOT(NSLOT)) u_dec (
        .dev (addr_q[DEV_LSB+4:DEV_LSB]),
        .sel (sel)
    );

    cfg_cycle_fmt #(.NSLOT(NSLOT)) u_fmt (
        .addr_q    (addr_q),
        .local_bus (local_bus),
        .sel       (sel),
        .type1     (fmt_type1),
        .ad        (fmt_ad)
    );

    always_comb begin
        io_rdata      = (hit_addr && !io_write && full_be) ? addr_q : '0;
        cyc_d         = cyc_q;
        cyc_d.valid   = 1'b0;
        idsel_d       = idsel_q;
        if (launch) begin
            cyc_d.valid = 1'b1;
            cyc_d.type1 = fmt_type1;
            cyc_d.cmd   = io_write ? CMD_CFG_WR : CMD_CFG_RD;
            cyc_d.ad    = fmt_ad;
            idsel_d     = fmt_type1 ? '0 : sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q   <= '0;
            idsel_q <= '0;
        end else begin
            cyc_q   <= cyc_d;
            idsel_q <= idsel_d;
        end
    end

    assign cyc_valid = cyc_q.valid;
    assign cyc_type1 = cyc_q.type1;
    assign cyc_cmd   = cyc_q.cmd;
    assign cyc_ad    = cyc_q.ad;
    assign cyc_idsel = idsel_q;

    logic [DW_AW-1:0] unused_low;
    assign unused_low = io_addr[IO_AW-1:2];

endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk #(
    parameter int                IO_AW     = 16,
    parameter int                NSLOT     = 8,
    parameter logic [IO_AW-1:0]  ADDR_PORT = IO_AW'(16'h0CF8),
    parameter logic [IO_AW-1:0]  DATA_PORT = IO_AW'(16'h0CFC)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_valid,
    input logic              io_write,
    input logic [IO_AW-1:0]  io_addr,
    input logic [3:0]        io_be,
    input logic [31:0]       addr_q,
    input logic              cyc_valid,
    input logic              cyc_type1,
    input logic [3:0]        cyc_cmd,
    input logic [31:0]       cyc_ad,
    input logic [NSLOT-1:0]  cyc_idsel
);

    logic a_hit, d_hit;
    assign a_hit = io_valid && (io_addr[IO_AW-1:2] == ADDR_PORT[IO_AW-1:2]);
    assign d_hit = io_valid && (io_addr[IO_AW-1:2] == DATA_PORT[IO_AW-1:2]);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        addr_q[30:24] == 7'd0 && addr_q[1:0] == 2'd0); // R2

    AST_PARTIAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (a_hit && io_write && io_be != 4'hF) |=> $stable(addr_q)); // R3

    AST_NO_CYCLE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (d_hit && !addr_q[31]) |=> !cyc_valid); // R4

    AST_TYPE0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !cyc_type1) |-> (cyc_ad[1:0] == 2'b00 && cyc_ad[15:11] == 5'd0)); // R5

    AST_IDSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cyc_idsel)); // R6

    AST_TYPE1_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_type1) |-> (cyc_idsel == '0 && cyc_ad[1:0] == 2'b01)); // R8

    AST_CMD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> cyc_cmd[3:1] == 3'b101); // R9

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid |-> ($stable(cyc_ad) && $stable(cyc_idsel) && $stable(cyc_cmd))); // R10

endmodule

bind cfg_port_xlate cfg_xlate_chk #(
    .IO_AW(IO_AW), .NSLOT(NSLOT), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
    .io_addr(io_addr), .io_be(io_be), .addr_q(addr_q),
    .cyc_valid(cyc_valid), .cyc_type1(cyc_type1), .cyc_cmd(cyc_cmd),
    .cyc_ad(cyc_ad), .cyc_idsel(cyc_idsel)
);

// File: tb/sim_cfg_port_xlate.sv
module sim_cfg_port_xlate;

    localparam int CLK_PERIOD = 10;
    localparam int NSLOT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_valid = 1'b0;
    logic        io_write = 1'b0;
    logic [15:0] io_addr = '0;
    logic [3:0]  io_be = '0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic [7:0]  local_bus = 8'd3;
    logic        cyc_valid;
    logic        cyc_type1;
    logic [3:0]  cyc_cmd;
    logic [31:0] cyc_ad;
    logic [NSLOT-1:0] cyc_idsel;

    int checks = 0;
    int fails = 0;

    // reference model state
    logic [31:0] m_addr = '0;
    logic        e_valid = 1'b0;
    logic        e_type1 = 1'b0;
    logic [3:0]  e_cmd = '0;
    logic [31:0] e_ad = '0;
    logic [NSLOT-1:0] e_idsel = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_port_xlate #(.IO_AW(16), .NSLOT(NSLOT)) u0 (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
        .io_addr(io_addr), .io_be(io_be), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .local_bus(local_bus), .cyc_valid(cyc_valid), .cyc_type1(cyc_type1),
        .cyc_cmd(cyc_cmd), .cyc_ad(cyc_ad), .cyc_idsel(cyc_idsel)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_outputs(input string tag);
        chk(cyc_valid == e_valid, {tag, " valid R10"}, 32'(cyc_valid), 32'(e_valid));
        chk(cyc_type1 == e_type1, {tag, " type R5/R8"}, 32'(cyc_type1), 32'(e_type1));
        chk(cyc_cmd == e_cmd, {tag, " cmd R9"}, 32'(cyc_cmd), 32'(e_cmd));
        chk(cyc_ad == e_ad, {tag, " ad"}, cyc_ad, e_ad);
        chk(cyc_idsel == e_idsel, {tag, " idsel R6/R7"}, 32'(cyc_idsel), 32'(e_idsel));
    endtask

    // reference step: inputs applied at negedge, model advances at posedge
    task automatic access(input bit v, input bit w, input logic [15:0] a, input logic [3:0] be,
                          input logic [31:0] wd, input string tag);
        logic [31:0] exp_rd;
        int bus, dev, fn, dw;
        bit is_a, is_d;
        io_valid = v; io_write = w; io_addr = a; io_be = be; io_wdata = wd;
        is_a = v && (a[15:2] == 14'(16'h0CF8 >> 2));
        is_d = v && (a[15:2] == 14'(16'h0CFC >> 2));
        #1;
        exp_rd = (is_a && !w && be == 4'hF) ? m_addr : 32'h0;
        if (is_a && !w) chk(io_rdata == exp_rd, {tag, " readback R2/R3"}, io_rdata, exp_rd);
        @(posedge clk);
        e_valid = 1'b0;
        if (is_d && be != 4'h0 && m_addr[31]) begin
            bus = int'(m_addr[23:16]); dev = int'(m_addr[15:11]);
            fn = int'(m_addr[10:8]); dw = int'(m_addr[7:2]);
            e_valid = 1'b1;
            e_cmd = w ? 4'b1011 : 4'b1010;
            if (bus == int'(local_bus)) begin
                e_type1 = 1'b0;
                e_idsel = (dev < NSLOT) ? NSLOT'(1 << dev) : '0;
                e_ad = 32'(fn * 256 + dw * 4);
                if (dev < NSLOT) e_ad = e_ad + 32'(1 << (16 + dev));
            end else begin
                e_type1 = 1'b1;
                e_idsel = '0;
                e_ad = 32'(bus * 65536 + dev * 2048 + fn * 256 + dw * 4 + 1);
            end
        end
        if (is_a && w && be == 4'hF) m_addr = wd & 32'h80FF_FFFC;
        @(negedge clk);
        cmp_outputs(tag);
    endtask

    function automatic logic [31:0] mk(bit en, int bus, int dev, int fn, int dw);
        return {en, 7'd0, 8'(bus), 5'(dev), 3'(fn), 6'(dw), 2'b00};
    endfunction

    task automatic launch(bit en, int bus, int dev, int fn, int dw, bit w, logic [15:0] port,
                          logic [3:0] be, string tag);
        access(1, 1, 16'h0CF8, 4'hF, mk(en, bus, dev, fn, dw), {tag, " setaddr"});
        access(1, w, port, be, 32'h1234_5678, tag);
        access(0, 0, 16'h0000, 4'h0, 32'h0, {tag, " idle"});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        cmp_outputs("R1 reset");
        rst_n = 1'b1;
        access(1, 0, 16'h0CF8, 4'hF, 32'h0, "R1 addr reset");

        // R2 full write with reserved bits set reads back masked
        access(1, 1, 16'h0CF8, 4'hF, 32'hFFFF_FFFF, "R2 write");
        access(1, 0, 16'h0CF8, 4'hF, 32'h0, "R2 read");
        chk(m_addr == 32'h80FF_FFFC, "R2 model", m_addr, 32'h80FF_FFFC);

        // R3 partial writes ignored, partial read gives zero
        access(1, 1, 16'h0CF8, 4'h3, 32'h0, "R3 partial wr");
        access(1, 1, 16'h0CF8, 4'h7, 32'h0, "R3 partial wr2");
        access(1, 0, 16'h0CF8, 4'hF, 32'h0, "R3 readback");
        access(1, 0, 16'h0CF8, 4'h1, 32'h0, "R3 partial rd");

        // R4 enable clear -> no cycle; zero byte enables -> no cycle
        launch(0, 3, 2, 1, 5, 0, 16'h0CFC, 4'hF, "R4 disabled");
        launch(1, 3, 2, 1, 5, 1, 16'h0CFC, 4'h0, "R4 no-be");

        // R5 R6 type 0 with devices 0, 3, last slot
        launch(1, 3, 0, 0, 0, 0, 16'h0CFC, 4'hF, "R5 R6 dev0 rd");
        launch(1, 3, 3, 2, 3, 1, 16'h0CFC, 4'hF, "R5 R6 dev3 wr");
        launch(1, 3, NSLOT - 1, 7, 63, 0, 16'h0CFD, 4'h2, "R6 last slot");

        // R7 device beyond slots
        launch(1, 3, NSLOT, 5, 17, 0, 16'h0CFC, 4'hF, "R7 dev past");
        launch(1, 3, 31, 1, 1, 1, 16'h0CFF, 4'h8, "R7 dev31");

        // R8 type 1 forwarded, R9 command codes, R10 byte lanes
        launch(1, 5, 9, 4, 10, 1, 16'h0CFE, 4'h4, "R8 R9 type1 wr");
        launch(1, 0, 31, 7, 63, 0, 16'h0CFC, 4'hF, "R8 R9 type1 rd");
        local_bus = 8'd5;
        launch(1, 5, 1, 0, 2, 0, 16'h0CFC, 4'hF, "R5 new local bus");

        // R10 hold over idle cycles and non-matching I/O
        access(1, 1, 16'h0080, 4'hF, 32'hFFFF_FFFF, "R10 other port");
        access(0, 0, 16'h0, 4'h0, 32'h0, "R10 idle1");
        access(0, 0, 16'h0, 4'h0, 32'h0, "R10 idle2");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule